// File: doc/BRIEF.md
# Up/Down Counter Input Capture Channel

This block is a single input-capture channel. A 16-bit counter runs up or down between zero and a programmable period. An external capture pin is synchronized, optionally inverted and gated, and its transitions are turned into single-cycle edge pulses. A rising edge copies the counter value from the cycle of the edge into a rising-capture register. A falling edge copies it into a separate falling-capture register.

Each edge direction has its own sticky flag, its own interrupt enable and its own counter-reload enable. A reload sends the counter back to its start point: the period value when counting down, zero when counting up. Software programs the channel through a small write-only register port. It measures pulse widths and periods by reading the two capture registers and the flags.

Register port (`cfg_addr`): 0 = control, 1 = period, 2 = flag clear. Control bits are: 0 capture enable, 1 invert, 2 pin enable, 3 reload on rise, 4 reload on fall, 5 rise interrupt enable, 6 fall interrupt enable, 7 count down, 8 run. Address 3 is ignored.

Top module: `cap_channel`

## Requirements
- R1: After reset the counter, both capture registers, both flags, the interrupt and the direction output are all zero.
- R2: With run set, counting up goes from 0 to the period and then returns to 0 when the count is at or above the period. Counting down goes to 0 and then returns to the period. `cnt_down_o` shows control bit 7.
- R3: A rising transition of the conditioned input copies the counter value present at the acting clock edge into `rise_cap_o` and sets `rise_flag_o`. The pin is acted on at the third rising clock edge after it changes. Rising and falling pulses never coincide.
- R4: A falling transition does the same into `fall_cap_o` and `fall_flag_o`.
- R5: With control bit 1 set, the pin is inverted before edge detection, so a pin rise is handled as a falling edge and a pin fall as a rising edge.
- R6: With control bit 2 clear, the conditioned input is held low and pin toggles change neither flag nor capture register.
- R7: With control bit 0 clear, no edge captures, sets a flag or reloads.
- R8: An edge whose reload bit (3 for rising, 4 for falling) is set loads the counter with the period when counting down, or with 0 when counting up, at the same clock edge.
- R9: An edge whose reload bit is clear leaves the counter counting normally.
- R10: When a capture reload and a natural wrap fall in the same cycle, the reload value is applied and the captured value is the counter value from before the reload (0 down, period up).
- R11: Writing 1 to bit 0 (rise) or bit 1 (fall) at address 2 clears that flag, and writing 0 leaves it. A flag set and its clear in the same cycle leave the flag set.
- R12: `irq_o` goes high one cycle after a flag whose interrupt enable is set, and goes low one cycle after no enabled flag remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CNT_W | Register write data |
| cap_pin | input | 1 | Asynchronous capture input |
| cnt_o | output | CNT_W | Live counter value |
| cnt_down_o | output | 1 | Counter direction, 1 = down |
| rise_cap_o | output | CNT_W | Value latched on the last rising edge |
| fall_cap_o | output | CNT_W | Value latched on the last falling edge |
| rise_flag_o | output | 1 | Sticky rising-capture flag |
| fall_flag_o | output | 1 | Sticky falling-capture flag |
| irq_o | output | 1 | Capture interrupt |

## Verification
Two collisions are forced on purpose. In the first, the bench waits until the counter is two steps from its wrap point and then moves the pin. The capture edge then lands exactly on the wrap, in both count directions. The bench judges the result by the captured value (0 or the period) and by the counter being at the reload value afterwards. In the second, the bench times a flag-clear write to hit the same clock edge as a new capture, and the flag must stay set. A cycle-level reference model runs beside the design. It feeds an expected-capture queue that a monitor drains, and it compares the counter every cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CTRL_BITS = 9;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_FLAGS  = 2'd2
  } reg_sel_e;

  // bit 0 is the last member
  typedef struct packed {
    logic run;
    logic count_down;
    logic fall_ie;
    logic rise_ie;
    logic fall_rld;
    logic rise_rld;
    logic pin_en;
    logic inv;
    logic cap_en;
  } ctrl_t;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pin_en_i,
  input  logic inv_i,
  input  logic cap_en_i,
  output logic rise_o,
  output logic fall_o
);
  logic synced;
  logic level;
  logic level_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= pin_i;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[SYNC_STAGES-2:0], pin_i};
      end
      assign synced = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // a disabled pin reads as a steady low level
  assign level = pin_en_i & (synced ^ inv_i);

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise_o = cap_en_i &  level & ~level_q;
  assign fall_o = cap_en_i & ~level &  level_q;
endmodule

// File: rtl/cap_updown_counter.sv
module cap_updown_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         down_i,
  input  logic [W-1:0] period_i,
  input  logic         reload_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] start_val;
  logic [W-1:0] step_val;

  assign start_val = down_i ? period_i : '0;

  always_comb begin
    if (down_i) step_val = (cnt_q == '0) ? period_i : cnt_q - 1'b1;
    else        step_val = (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
  end

  // a capture reload takes precedence over the natural wrap
  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (reload_i) cnt_q <= start_val;
    else if (run_i)    cnt_q <= step_val;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cap_latch_bank.sv
module cap_latch_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic [W-1:0] cnt_i,
  input  logic         rise_ie_i,
  input  logic         fall_ie_i,
  input  logic         clr_rise_i,
  input  logic         clr_fall_i,
  output logic [W-1:0] rise_cap_o,
  output logic [W-1:0] fall_cap_o,
  output logic         rise_flag_o,
  output logic         fall_flag_o,
  output logic         irq_o
);
  logic [W-1:0] rise_cap_q, fall_cap_q;
  logic         rise_flag_q, fall_flag_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_cap_q <= '0;
      fall_cap_q <= '0;
    end else begin
      if (rise_i) rise_cap_q <= cnt_i;
      if (fall_i) fall_cap_q <= cnt_i;
    end
  end

  // set dominates a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_flag_q <= 1'b0;
      fall_flag_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (rise_i)          rise_flag_q <= 1'b1;
      else if (clr_rise_i) rise_flag_q <= 1'b0;
      if (fall_i)          fall_flag_q <= 1'b1;
      else if (clr_fall_i) fall_flag_q <= 1'b0;
      irq_q <= (rise_flag_q & rise_ie_i) | (fall_flag_q & fall_ie_i);
    end
  end

  assign rise_cap_o  = rise_cap_q;
  assign fall_cap_o  = fall_cap_q;
  assign rise_flag_o = rise_flag_q;
  assign fall_flag_o = fall_flag_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             cap_pin,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cnt_down_o,
  output logic [CNT_W-1:0] rise_cap_o,
  output logic [CNT_W-1:0] fall_cap_o,
  output logic             rise_flag_o,
  output logic             fall_flag_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic             rise_pulse, fall_pulse, reload;
  logic             clr_rise, clr_fall;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == REG_CTRL)   ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_BITS-1:0]);
      if (cfg_addr == REG_PERIOD) period_q <= cfg_wdata;
    end
  end

  assign clr_rise = cfg_we && (cfg_addr == REG_FLAGS) && cfg_wdata[0];
  assign clr_fall = cfg_we && (cfg_addr == REG_FLAGS) && cfg_wdata[1];

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_i(cap_pin),
    .pin_en_i(ctrl_q.pin_en), .inv_i(ctrl_q.inv), .cap_en_i(ctrl_q.cap_en),
    .rise_o(rise_pulse), .fall_o(fall_pulse)
  );

  assign reload = (rise_pulse & ctrl_q.rise_rld) | (fall_pulse & ctrl_q.fall_rld);

  cap_updown_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(ctrl_q.run), .down_i(ctrl_q.count_down),
    .period_i(period_q), .reload_i(reload), .cnt_o(cnt)
  );

  cap_latch_bank #(.W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .rise_i(rise_pulse), .fall_i(fall_pulse), .cnt_i(cnt),
    .rise_ie_i(ctrl_q.rise_ie), .fall_ie_i(ctrl_q.fall_ie),
    .clr_rise_i(clr_rise), .clr_fall_i(clr_fall),
    .rise_cap_o(rise_cap_o), .fall_cap_o(fall_cap_o),
    .rise_flag_o(rise_flag_o), .fall_flag_o(fall_flag_o), .irq_o(irq_o)
  );

  assign cnt_o      = cnt;
  assign cnt_down_o = ctrl_q.count_down;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         rise_pulse,
  input logic         fall_pulse,
  input logic         reload,
  input logic         count_down,
  input logic [W-1:0] period,
  input logic [W-1:0] cnt,
  input logic [W-1:0] rise_cap,
  input logic         rise_flag,
  input logic         fall_flag,
  input logic         irq
);
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(rise_pulse && fall_pulse)); // R3
  AST_RISE_CAP_HOLD: assert property (@(posedge clk) disable iff (rst) !rise_pulse |=> $stable(rise_cap)); // R3
  AST_RISE_FLAG_SET: assert property (@(posedge clk) disable iff (rst) rise_pulse |=> rise_flag); // R11
  AST_RELOAD_DOWN: assert property (@(posedge clk) disable iff (rst) (reload && count_down) |=> cnt == $past(period)); // R8
  AST_RELOAD_UP: assert property (@(posedge clk) disable iff (rst) (reload && !count_down) |=> cnt == '0); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) (!rise_flag && !fall_flag) |=> !irq); // R12
endmodule

bind cap_channel cap_channel_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
  .reload(reload), .count_down(ctrl_q.count_down), .period(period_q), .cnt(cnt),
  .rise_cap(rise_cap_o), .rise_flag(rise_flag_o), .fall_flag(fall_flag_o), .irq(irq_o)
);

// File: tb/tb_cap_channel.sv
module tb_cap_channel;
  import cap_pkg::*;
  localparam int W = 16;
  localparam logic [15:0] C_CAPEN = 16'h001, C_INV = 16'h002, C_PINEN = 16'h004,
    C_RRLD = 16'h008, C_FRLD = 16'h010, C_RIE = 16'h020, C_DOWN = 16'h080, C_RUN = 16'h100;
  localparam logic [15:0] PER = 16'd9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, cfg_we = 1'b0, cap_pin = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cnt_o, rise_cap_o, fall_cap_o;
  logic cnt_down_o, rise_flag_o, fall_flag_o, irq_o;

  cap_channel #(.CNT_W(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cap_pin(cap_pin), .cnt_o(cnt_o), .cnt_down_o(cnt_down_o), .rise_cap_o(rise_cap_o),
    .fall_cap_o(fall_cap_o), .rise_flag_o(rise_flag_o), .fall_flag_o(fall_flag_o), .irq_o(irq_o)
  );

  int tests = 0, fails = 0, cnt_bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model, evaluated from the requirements
  typedef struct { bit is_fall; logic [W-1:0] val; } exp_t;
  exp_t sb[$];
  ctrl_t m_ctrl;
  logic [W-1:0] m_period, m_cnt;
  logic m_s1, m_s2, m_prev, m_lvl, m_r, m_f, m_rl;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_period = '0; m_cnt = '0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      m_lvl = m_ctrl.pin_en & (m_s2 ^ m_ctrl.inv);
      m_r = m_ctrl.cap_en & m_lvl & ~m_prev;
      m_f = m_ctrl.cap_en & ~m_lvl & m_prev;
      if (m_r) sb.push_back('{1'b0, m_cnt});
      if (m_f) sb.push_back('{1'b1, m_cnt});
      m_rl = (m_r & m_ctrl.rise_rld) | (m_f & m_ctrl.fall_rld);
      if (m_rl) m_cnt = m_ctrl.count_down ? m_period : '0;
      else if (m_ctrl.run) begin
        if (m_ctrl.count_down) m_cnt = (m_cnt == 0) ? m_period : m_cnt - 1'b1;
        else                   m_cnt = (m_cnt >= m_period) ? '0 : m_cnt + 1'b1;
      end
      m_prev = m_lvl; m_s2 = m_s1; m_s1 = cap_pin;
      if (cfg_we && cfg_addr == 2'd0) m_ctrl = ctrl_t'(cfg_wdata[8:0]);
      if (cfg_we && cfg_addr == 2'd1) m_period = cfg_wdata;
    end
  end

  // monitor: drains expected captures, tracks the counter
  always @(negedge clk) begin
    if (!rst) begin
      if (cnt_o !== m_cnt) begin
        if (cnt_bad < 4) $display("note: counter %0d vs model %0d at %0t", cnt_o, m_cnt, $time);
        cnt_bad++;
      end
      while (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        if (!it.is_fall) begin
          chk("R3", "rise capture value", rise_cap_o, it.val);
          chk("R11", "rise flag set", rise_flag_o, 1);
        end else begin
          chk("R4", "fall capture value", fall_cap_o, it.val);
          chk("R11", "fall flag set", fall_flag_o, 1);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic clr();
    wr(2'd2, 16'h3);
  endtask
  task automatic pin(input logic v);
    @(negedge clk); cap_pin = v; idle(3);
  endtask
  task automatic wait_cnt(input logic [W-1:0] v);
    do @(negedge clk); while (cnt_o !== v);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] rc, fc;
    idle(4); rst = 0; idle(1);
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "rise cap", rise_cap_o, 0);
    chk("R1", "fall cap", fall_cap_o, 0);
    chk("R1", "flags", {rise_flag_o, fall_flag_o}, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "dir", cnt_down_o, 0);

    wr(2'd1, PER);
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN);
    idle(25);
    wait_cnt(PER); idle(1);
    chk("R2", "up wrap", cnt_o, 0);

    pin(1);
    chk("R3", "rise flag", rise_flag_o, 1);
    chk("R3", "no fall flag", fall_flag_o, 0);
    clr();
    pin(0);
    chk("R4", "fall flag", fall_flag_o, 1);
    clr();

    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_DOWN | C_RRLD);
    idle(3);
    chk("R2", "direction out", cnt_down_o, 1);
    wait_cnt(0); idle(1);
    chk("R2", "down wrap", cnt_o, PER);
    wait_cnt(6); pin(1);
    chk("R8", "down reload on rise", cnt_o, PER);
    clr();
    wait_cnt(6); cap_pin = 0; idle(3);
    chk("R4", "fall value", fall_cap_o, 4);
    chk("R9", "no reload on fall", cnt_o, 3);
    clr();

    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_RRLD);
    wait_cnt(3); cap_pin = 1; idle(3);
    chk("R3", "rise value up", rise_cap_o, 5);
    chk("R8", "up reload to zero", cnt_o, 0);
    clr(); pin(0); clr();

    // collisions with the natural wrap
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_DOWN | C_RRLD | C_FRLD);
    wait_cnt(2); cap_pin = 1; idle(3);
    chk("R10", "down rise latched 0", rise_cap_o, 0);
    chk("R10", "down rise cnt", cnt_o, PER);
    wait_cnt(2); cap_pin = 0; idle(3);
    chk("R10", "down fall latched 0", fall_cap_o, 0);
    chk("R10", "down fall cnt", cnt_o, PER);
    clr();
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_RRLD);
    wait_cnt(PER - 2); cap_pin = 1; idle(3);
    chk("R10", "up rise latched period", rise_cap_o, PER);
    chk("R10", "up rise cnt", cnt_o, 0);
    clr(); pin(0); clr();

    // inversion
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_INV); idle(3); clr();
    pin(1);
    chk("R5", "inverted rise -> fall flag", fall_flag_o, 1);
    chk("R5", "inverted rise -> no rise flag", rise_flag_o, 0);
    clr();
    pin(0);
    chk("R5", "inverted fall -> rise flag", rise_flag_o, 1);
    chk("R5", "inverted fall -> no fall flag", fall_flag_o, 0);
    clr();
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN); idle(3); clr();

    // pin disabled
    wr(2'd0, C_RUN | C_CAPEN); idle(3); clr();
    rc = rise_cap_o; fc = fall_cap_o;
    pin(1); idle(2); pin(0); idle(2); pin(1); idle(2);
    chk("R6", "flags with pin off", {rise_flag_o, fall_flag_o}, 0);
    chk("R6", "rise cap kept", rise_cap_o, rc);
    chk("R6", "fall cap kept", fall_cap_o, fc);
    pin(0);
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN); idle(3); clr();

    // capture disabled
    wr(2'd0, C_RUN | C_PINEN | C_RRLD);
    rc = rise_cap_o; fc = fall_cap_o;
    pin(1); idle(2); pin(0); idle(2);
    chk("R7", "flags with capture off", {rise_flag_o, fall_flag_o}, 0);
    chk("R7", "rise cap kept", rise_cap_o, rc);
    chk("R7", "fall cap kept", fall_cap_o, fc);

    // interrupt
    wr(2'd0, C_RUN | C_CAPEN | C_PINEN | C_RIE);
    pin(1);
    chk("R12", "irq lags flag", irq_o, 0);
    idle(1);
    chk("R12", "irq raised", irq_o, 1);
    pin(0);
    chk("R12", "irq held by rise flag", irq_o, 1);
    clr(); idle(1);
    chk("R12", "irq dropped", irq_o, 0);
    chk("R11", "flags cleared", {rise_flag_o, fall_flag_o}, 0);

    // set wins over same-cycle clear
    pin(1); pin(0);
    @(negedge clk); cap_pin = 1;
    idle(1);
    @(negedge clk); cfg_we = 1; cfg_addr = 2'd2; cfg_wdata = 16'h1;
    @(negedge clk); cfg_we = 0;
    chk("R11", "set beats clear", rise_flag_o, 1);
    wr(2'd2, 16'h2);
    chk("R11", "clear fall only", {rise_flag_o, fall_flag_o}, 2'b10);
    wr(2'd2, 16'h0);
    chk("R11", "zero write keeps", rise_flag_o, 1);
    wr(2'd2, 16'h1);
    chk("R11", "clear rise", rise_flag_o, 0);

    idle(4);
    chk("R2", "counter mismatches vs model", cnt_bad, 0);
    summary();
    $finish;
  end
endmodule